// File: doc/BRIEF.md
# Page Address Translation Unit

This block turns a virtual address into a physical address. The address splits into a virtual page number and a byte offset. Only the page number is translated, and the offset is passed through to the low bits of the physical address. A small fully associative translation buffer holds recently used page mappings. It answers a hit in the same cycle as the request.

On a buffer miss the block spends one cycle reading a direct-indexed page table, which has one entry per virtual page. If the page is resident, the block refills the buffer. If the page is not resident, it reports a page fault. Each table entry carries these fields:
- the physical page number
- a resident bit
- a modified bit
- a use bit
- two protection bits

An access that its protection bits forbid reports a protection fault. Write accesses mark the page as modified.

A loader port fills the table one entry per cycle. The same index also reads an entry back combinationally. The buffer does not track changes to the table. After the table is edited, the invalidate input drops every cached mapping in one cycle. A requester holds `req_i` and its address until `done_o` is high.

Top module: `xlat_top`

## Requirements
- R1: The physical address is `{ppn, offset}`. The offset is the low `PG_W` bits of `vaddr_i`, passed through unchanged. The page number is `vaddr_i[VA_W-1:PG_W]`. The address is driven only with a successful `done_o`; otherwise `paddr_o` is zero.
- R2: A request whose page is held in the buffer completes in the same cycle (`done_o` high, no fault) with the buffered physical page.
- R3: A request that misses the buffer keeps `done_o` low for one cycle and completes in the next cycle from the page table. When the page is resident, its mapping is then loaded into the buffer, so the next request to that page hits.
- R4: A miss to a page whose resident bit is 0 completes with `page_fault_o` high and `paddr_o` zero. The buffer is not refilled, so a repeat request misses again.
- R5: Protection bit 0 allows reads and bit 1 allows writes. A disallowed access completes with `prot_fault_o` high, and neither the modified bit nor the use bit changes. A resident page still refills the buffer after a miss that faults on protection.
- R6: A successful write sets the buffer entry's modified bit. It sets the table's modified bit unless the buffer entry was already marked modified.
- R7: Any successful translation sets the page's use bit in the table.
- R8: A refill takes the lowest-numbered empty buffer entry. When all entries are valid, it takes the entry at a round-robin pointer, which starts at 0 after reset or invalidate and advances by one, wrapping, on each such eviction.
- R9: `inv_i` empties the buffer in one cycle and resets the round-robin pointer. Until then, a buffered mapping keeps being used after its table entry is rewritten.
- R10: With `pt_ld_i` high, the entry at `pt_idx_i` takes the page number, protection and resident bit from the loader inputs and clears its modified and use bits. The `pt_*_o` outputs always show the entry at `pt_idx_i`.
- R11: After reset, no request is done or faulted until translated, every table entry is non-resident, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request, held until done |
| we_i | input | 1 | Access is a write |
| vaddr_i | input | VA_W | Virtual address |
| inv_i | input | 1 | Empty the translation buffer |
| pt_ld_i | input | 1 | Write the table entry at pt_idx_i |
| pt_idx_i | input | VA_W-PG_W | Table index for load and read-back |
| pt_ppn_i | input | PA_W-PG_W | Physical page to load |
| pt_prot_i | input | 2 | Protection to load (bit0 read, bit1 write) |
| pt_res_i | input | 1 | Resident bit to load |
| done_o | output | 1 | Request complete |
| paddr_o | output | PA_W | Physical address |
| page_fault_o | output | 1 | Page not resident |
| prot_fault_o | output | 1 | Access not permitted |
| pt_ppn_o | output | PA_W-PG_W | Read-back: physical page |
| pt_prot_o | output | 2 | Read-back: protection |
| pt_res_o | output | 1 | Read-back: resident |
| pt_mod_o | output | 1 | Read-back: modified |
| pt_used_o | output | 1 | Read-back: use bit |

## Verification
The hardest case to reach is round-robin eviction. It happens only after every buffer entry is valid, and a single request never shows which entry it replaced. The stimulus makes 40 pages resident and sweeps them in order, which overflows the 32-entry buffer. It then revisits early pages, where the hit-or-miss timing of each request shows which entries were evicted. The skipped table write of R6 also needs a setup the ports do not give directly. The stimulus writes a page so that its buffer entry is marked modified, then reloads the table entry with its modified bit cleared, then writes the page again and reads back a modified bit that is still clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} walk_st_e;

  localparam int unsigned PROT_W  = 2;
  localparam int unsigned PROT_RD = 0;
  localparam int unsigned PROT_WR = 1;

  function automatic logic prot_ok(input logic [PROT_W-1:0] prot, input logic wr);
    return wr ? prot[PROT_WR] : prot[PROT_RD];
  endfunction
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 6,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [PROT_W-1:0] lk_prot_o,
  output logic              lk_dirty_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PROT_W-1:0] fill_prot_i,
  input  logic              fill_dirty_i,
  input  logic              dirty_set_i,
  input  logic [IDX_W-1:0]  dirty_idx_i
);
  logic [N-1:0]      valid_q, dirty_q, match;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [PPN_W-1:0]  ppn_q  [N];
  logic [PROT_W-1:0] prot_q [N];
  logic [IDX_W-1:0]  rr_q, free_idx, victim;
  logic              free_any;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn_i);
  end

  always_comb begin
    lk_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) if (match[i]) lk_idx_o = IDX_W'(i);
  end

  assign lk_hit_o   = |match;
  assign lk_ppn_o   = ppn_q[lk_idx_o];
  assign lk_prot_o  = prot_q[lk_idx_o];
  assign lk_dirty_o = dirty_q[lk_idx_o];

  // lowest empty slot first, round-robin only when full
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) if (!valid_q[i]) free_idx = IDX_W'(i);
  end
  assign free_any = ~&valid_q;
  assign victim   = free_any ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      rr_q    <= '0;
    end else begin
      if (inv_i) begin
        valid_q <= '0;
        rr_q    <= '0;
      end
      if (dirty_set_i) dirty_q[dirty_idx_i] <= 1'b1;
      if (fill_i) begin
        valid_q[victim] <= 1'b1;
        dirty_q[victim] <= fill_dirty_i;
        if (!free_any) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      vpn_q[victim]  <= fill_vpn_i;
      ppn_q[victim]  <= fill_ppn_i;
      prot_q[victim] <= fill_prot_i;
    end
  end
endmodule

// File: rtl/xlat_page_table.sv
module xlat_page_table
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [VPN_W-1:0]  ld_idx_i,
  input  logic [PPN_W-1:0]  ld_ppn_i,
  input  logic [PROT_W-1:0] ld_prot_i,
  input  logic              ld_res_i,
  input  logic              upd_i,
  input  logic [VPN_W-1:0]  upd_vpn_i,
  input  logic              upd_mod_i,
  input  logic [VPN_W-1:0]  rd_vpn_i,
  output logic [PPN_W-1:0]  rd_ppn_o,
  output logic [PROT_W-1:0] rd_prot_o,
  output logic              rd_res_o,
  output logic [PPN_W-1:0]  obs_ppn_o,
  output logic [PROT_W-1:0] obs_prot_o,
  output logic              obs_res_o,
  output logic              obs_mod_o,
  output logic              obs_used_o
);
  localparam int unsigned DEPTH = 1 << VPN_W;

  logic [PPN_W-1:0]  ppn_q  [DEPTH];
  logic [PROT_W-1:0] prot_q [DEPTH];
  logic [DEPTH-1:0]  res_q, mod_q, used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      mod_q  <= '0;
      used_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ppn_q[i]  <= '0;
        prot_q[i] <= '0;
      end
    end else begin
      if (upd_i) begin
        used_q[upd_vpn_i] <= 1'b1;
        if (upd_mod_i) mod_q[upd_vpn_i] <= 1'b1;
      end
      // loader wins over a same-cycle update
      if (ld_i) begin
        ppn_q[ld_idx_i]  <= ld_ppn_i;
        prot_q[ld_idx_i] <= ld_prot_i;
        res_q[ld_idx_i]  <= ld_res_i;
        mod_q[ld_idx_i]  <= 1'b0;
        used_q[ld_idx_i] <= 1'b0;
      end
    end
  end

  assign rd_ppn_o   = ppn_q[rd_vpn_i];
  assign rd_prot_o  = prot_q[rd_vpn_i];
  assign rd_res_o   = res_q[rd_vpn_i];
  assign obs_ppn_o  = ppn_q[ld_idx_i];
  assign obs_prot_o = prot_q[ld_idx_i];
  assign obs_res_o  = res_q[ld_idx_i];
  assign obs_mod_o  = mod_q[ld_idx_i];
  assign obs_used_o = used_q[ld_idx_i];
endmodule

// File: rtl/xlat_top.sv
module xlat_top
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned PA_W  = 14,
  parameter int unsigned PG_W  = 8,
  parameter int unsigned TLB_N = 32,
  localparam int unsigned VPN_W = VA_W - PG_W,
  localparam int unsigned PPN_W = PA_W - PG_W,
  localparam int unsigned IDX_W = $clog2(TLB_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              inv_i,
  input  logic              pt_ld_i,
  input  logic [VPN_W-1:0]  pt_idx_i,
  input  logic [PPN_W-1:0]  pt_ppn_i,
  input  logic [PROT_W-1:0] pt_prot_i,
  input  logic              pt_res_i,
  output logic              done_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic              page_fault_o,
  output logic              prot_fault_o,
  output logic [PPN_W-1:0]  pt_ppn_o,
  output logic [PROT_W-1:0] pt_prot_o,
  output logic              pt_res_o,
  output logic              pt_mod_o,
  output logic              pt_used_o
);
  walk_st_e st_q, st_d;
  logic [VPN_W-1:0]  vpn, vpn_q, upd_vpn;
  logic [PG_W-1:0]   off, off_q;
  logic              we_q;

  logic              hit, hit_dirty;
  logic [IDX_W-1:0]  hit_idx;
  logic [PPN_W-1:0]  hit_ppn, tab_ppn;
  logic [PROT_W-1:0] hit_prot, tab_prot;
  logic              tab_res;
  logic              fill, fill_dirty, dset, upd, upd_mod;

  assign vpn = vaddr_i[VA_W-1:PG_W];
  assign off = vaddr_i[PG_W-1:0];
  assign upd_vpn = (st_q == ST_WALK) ? vpn_q : vpn;

  xlat_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk_i, .rst_ni, .inv_i,
    .lk_vpn_i(vpn), .lk_hit_o(hit), .lk_idx_o(hit_idx), .lk_ppn_o(hit_ppn),
    .lk_prot_o(hit_prot), .lk_dirty_o(hit_dirty),
    .fill_i(fill), .fill_vpn_i(vpn_q), .fill_ppn_i(tab_ppn), .fill_prot_i(tab_prot),
    .fill_dirty_i(fill_dirty), .dirty_set_i(dset), .dirty_idx_i(hit_idx)
  );

  xlat_page_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_pt (
    .clk_i, .rst_ni,
    .ld_i(pt_ld_i), .ld_idx_i(pt_idx_i), .ld_ppn_i(pt_ppn_i), .ld_prot_i(pt_prot_i),
    .ld_res_i(pt_res_i), .upd_i(upd), .upd_vpn_i(upd_vpn), .upd_mod_i(upd_mod),
    .rd_vpn_i(vpn_q), .rd_ppn_o(tab_ppn), .rd_prot_o(tab_prot), .rd_res_o(tab_res),
    .obs_ppn_o(pt_ppn_o), .obs_prot_o(pt_prot_o), .obs_res_o(pt_res_o),
    .obs_mod_o(pt_mod_o), .obs_used_o(pt_used_o)
  );

  always_comb begin
    st_d         = st_q;
    done_o       = 1'b0;
    page_fault_o = 1'b0;
    prot_fault_o = 1'b0;
    paddr_o      = '0;
    upd          = 1'b0;
    upd_mod      = 1'b0;
    fill         = 1'b0;
    fill_dirty   = 1'b0;
    dset         = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          if (hit) begin
            done_o = 1'b1;
            if (!prot_ok(hit_prot, we_i)) begin
              prot_fault_o = 1'b1;
            end else begin
              paddr_o = {hit_ppn, off};
              upd     = 1'b1;
              upd_mod = we_i && !hit_dirty;
              dset    = we_i;
            end
          end else begin
            st_d = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        done_o = 1'b1;
        st_d   = ST_IDLE;
        if (!tab_res) begin
          page_fault_o = 1'b1;
        end else begin
          fill = 1'b1;
          if (!prot_ok(tab_prot, we_q)) begin
            prot_fault_o = 1'b1;
          end else begin
            paddr_o    = {tab_ppn, off_q};
            upd        = 1'b1;
            upd_mod    = we_q;
            fill_dirty = we_q;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      vpn_q <= '0;
      off_q <= '0;
      we_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i && !hit) begin
        vpn_q <= vpn;
        off_q <= off;
        we_q  <= we_i;
      end
    end
  end
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned PA_W  = 14,
  parameter int unsigned PG_W  = 8,
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [VA_W-1:0]  vaddr_i,
  input logic             inv_i,
  input logic             pt_ld_i,
  input logic [VPN_W-1:0] pt_idx_i,
  input logic [PPN_W-1:0] pt_ppn_i,
  input logic [PPN_W-1:0] pt_ppn_o,
  input logic             done_o,
  input logic [PA_W-1:0]  paddr_o,
  input logic             page_fault_o,
  input logic             prot_fault_o
);
  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !page_fault_o && !prot_fault_o |-> paddr_o[PG_W-1:0] == vaddr_i[PG_W-1:0]);

  // R3
  miss_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !done_o |=> done_o);

  // R4
  fault_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_fault_o |-> done_o && paddr_o == '0);

  // R5
  prot_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> done_o && !page_fault_o);

  // R9
  inv_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i && !req_i |=> !done_o);

  // R10
  load_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_ld_i |=> ($stable(pt_idx_i) -> pt_ppn_o == $past(pt_ppn_i)));
endmodule

bind xlat_top xlat_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .vaddr_i(vaddr_i), .inv_i(inv_i),
  .pt_ld_i(pt_ld_i), .pt_idx_i(pt_idx_i), .pt_ppn_i(pt_ppn_i), .pt_ppn_o(pt_ppn_o),
  .done_o(done_o), .paddr_o(paddr_o), .page_fault_o(page_fault_o),
  .prot_fault_o(prot_fault_o)
);

// File: tb/tb_xlat_top.sv
module tb_xlat_top;
  localparam int CLK_P = 10;
  localparam int VA_W  = 16;
  localparam int PA_W  = 14;
  localparam int PG_W  = 8;
  localparam int TLB_N = 32;
  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = PA_W - PG_W;
  localparam int NPG   = 1 << VPN_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, inv_i = 1'b0, pt_ld_i = 1'b0, pt_res_i = 1'b0;
  logic [VA_W-1:0]  vaddr_i = '0;
  logic [VPN_W-1:0] pt_idx_i = '0;
  logic [PPN_W-1:0] pt_ppn_i = '0;
  logic [1:0]       pt_prot_i = '0;
  logic done_o, page_fault_o, prot_fault_o, pt_res_o, pt_mod_o, pt_used_o;
  logic [PA_W-1:0]  paddr_o;
  logic [PPN_W-1:0] pt_ppn_o;
  logic [1:0]       pt_prot_o;

  always #(CLK_P / 2) clk = ~clk;

  xlat_top #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W), .TLB_N(TLB_N)) dut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .vaddr_i, .inv_i, .pt_ld_i, .pt_idx_i,
    .pt_ppn_i, .pt_prot_i, .pt_res_i, .done_o, .paddr_o, .page_fault_o, .prot_fault_o,
    .pt_ppn_o, .pt_prot_o, .pt_res_o, .pt_mod_o, .pt_used_o
  );

  int checks = 0, bad = 0;
  bit finished = 0;

  // reference state
  bit m_res [NPG];
  int m_ppn [NPG];
  int m_prot[NPG];
  bit m_mod [NPG];
  bit m_used[NPG];
  bit t_v    [TLB_N];
  int t_vpn  [TLB_N];
  int t_ppn  [TLB_N];
  int t_prot [TLB_N];
  bit t_dirty[TLB_N];
  int rr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit allowed(input int prot, input bit wr);
    return wr ? bit'((prot >> 1) & 1) : bit'(prot & 1);
  endfunction

  task automatic access(input int vpn, input int off, input bit wr, input string tag);
    int hi;
    int v;
    bit ok;
    @(negedge clk);
    req_i = 1'b1; we_i = wr; vaddr_i = VA_W'((vpn << PG_W) | off);
    hi = -1;
    for (int i = 0; i < TLB_N; i++) if (hi < 0 && t_v[i] && t_vpn[i] == vpn) hi = i;
    #1;
    if (hi >= 0) begin
      ok = allowed(t_prot[hi], wr);
      chk({tag, " hit done"}, int'(done_o), 1);
      chk({tag, " hit pf"}, int'(page_fault_o), 0);
      chk({tag, " hit xf"}, int'(prot_fault_o), int'(!ok));
      if (ok) begin
        chk({tag, " hit paddr"}, int'(paddr_o), (t_ppn[hi] << PG_W) | off);
        m_used[vpn] = 1;
        if (wr && !t_dirty[hi]) m_mod[vpn] = 1;
        if (wr) t_dirty[hi] = 1;
      end
    end else begin
      chk({tag, " miss wait"}, int'(done_o), 0);
      @(negedge clk); #1;
      chk({tag, " walk done"}, int'(done_o), 1);
      chk({tag, " walk pf"}, int'(page_fault_o), int'(!m_res[vpn]));
      if (m_res[vpn]) begin
        ok = allowed(m_prot[vpn], wr);
        chk({tag, " walk xf"}, int'(prot_fault_o), int'(!ok));
        v = -1;
        for (int i = 0; i < TLB_N; i++) if (v < 0 && !t_v[i]) v = i;
        if (v < 0) begin v = rr; rr = (rr + 1) % TLB_N; end
        t_v[v] = 1; t_vpn[v] = vpn; t_ppn[v] = m_ppn[vpn]; t_prot[v] = m_prot[vpn];
        t_dirty[v] = wr && ok;
        if (ok) begin
          chk({tag, " walk paddr"}, int'(paddr_o), (m_ppn[vpn] << PG_W) | off);
          m_used[vpn] = 1;
          if (wr) m_mod[vpn] = 1;
        end
      end else begin
        chk({tag, " walk xf"}, int'(prot_fault_o), 0);
        chk({tag, " walk paddr"}, int'(paddr_o), 0);
      end
    end
  endtask

  task automatic idle();
    @(negedge clk); req_i = 1'b0; #1;
    chk("idle done", int'(done_o), 0);
  endtask

  task automatic load(input int vpn, input int ppn, input int prot, input bit res);
    @(negedge clk);
    req_i = 1'b0; pt_ld_i = 1'b1; pt_idx_i = VPN_W'(vpn);
    pt_ppn_i = PPN_W'(ppn); pt_prot_i = 2'(prot); pt_res_i = res;
    @(negedge clk);
    pt_ld_i = 1'b0;
    m_res[vpn] = res; m_ppn[vpn] = ppn; m_prot[vpn] = prot; m_mod[vpn] = 0; m_used[vpn] = 0;
  endtask

  task automatic obs(input int vpn, input string tag);
    @(negedge clk); req_i = 1'b0; pt_idx_i = VPN_W'(vpn); #1;
    chk({tag, " res"}, int'(pt_res_o), int'(m_res[vpn]));
    chk({tag, " ppn"}, int'(pt_ppn_o), m_ppn[vpn]);
    chk({tag, " prot"}, int'(pt_prot_o), m_prot[vpn]);
    chk({tag, " mod"}, int'(pt_mod_o), int'(m_mod[vpn]));
    chk({tag, " used"}, int'(pt_used_o), int'(m_used[vpn]));
  endtask

  task automatic invalidate();
    @(negedge clk); req_i = 1'b0; inv_i = 1'b1;
    @(negedge clk); inv_i = 1'b0;
    for (int i = 0; i < TLB_N; i++) t_v[i] = 0;
    rr = 0;
  endtask

  function automatic int prot_of(input int v);
    if (v == 5) return 2;           // write only
    if (v % 4 == 3) return 1;       // read only
    return 3;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPG; i++) begin
      m_res[i] = 0; m_ppn[i] = 0; m_prot[i] = 0; m_mod[i] = 0; m_used[i] = 0;
    end
    for (int i = 0; i < TLB_N; i++) begin
      t_v[i] = 0; t_vpn[i] = 0; t_ppn[i] = 0; t_prot[i] = 0; t_dirty[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset done", int'(done_o), 0);
    chk("R11 reset pf", int'(page_fault_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    obs(0, "R11 reset pt0");
    obs(77, "R11 reset pt77");
    access(9, 4, 0, "R11 empty buffer");   // R11: misses, page fault on empty table
    idle();

    for (int v = 0; v < 40; v++) load(v, (v * 7 + 3) % 64, prot_of(v), 1);
    obs(6, "R10 loaded");

    access(1, 8'h21, 0, "R3 first");
    access(1, 8'h5a, 0, "R2 again");
    access(1, 8'hff, 1, "R6 write hit");
    obs(1, "R6 R7 page1");
    access(1, 8'h00, 1, "R6 rewrite");
    obs(1, "R6 page1 still");

    access(3, 8'h10, 1, "R5 ro write miss");
    obs(3, "R5 no mod");
    access(3, 8'h11, 1, "R5 ro write hit");
    access(3, 8'h12, 0, "R5 ro read");
    access(5, 8'h01, 0, "R5 wo read");
    obs(5, "R5 wo untouched");

    access(40, 8'h33, 0, "R4 nonres");
    access(40, 8'h34, 1, "R4 nonres again");
    access(2, 8'h80, 1, "R6 write miss");
    obs(2, "R6 page2");
    idle();

    for (int v = 0; v < 40; v++) access(v, v, 0, "R8 sweep");
    for (int v = 0; v < 10; v++) access(v, 8'h40 + v, 0, "R8 revisit");
    idle();

    // R9: stale mapping until invalidate
    load(12, 50, 3, 1);
    access(12, 8'h07, 0, "R9 stale");
    invalidate();
    access(12, 8'h07, 0, "R9 after inv");
    access(12, 8'h08, 1, "R6 dirty entry");
    load(12, 50, 3, 1);
    access(12, 8'h09, 1, "R6 dirty hit");
    obs(12, "R6 mod skipped");
    invalidate();
    for (int v = 20; v < 24; v++) access(v, 8'h3c, 0, "R8 refill low");
    idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule